// File: doc/BRIEF.md
# I2C Bus Clock Divider Solver

This block picks the two divider counts that set an I2C controller's bus clock. The bus clock equals the source clock divided by a fixed factor of two, then by a sample count, then by a step count. Given the source clock frequency and the wanted bus rate, both in Hz, the solver finds the pair whose product is the smallest one that still keeps the bus at or below the wanted rate. It also reports the register codes for that pair.

A single-cycle `start` pulse latches both frequencies. A restoring divider then forms the target divisor over one cycle per numerator bit. The engine then tries each sample count from 1 to 8, one per clock cycle, and keeps the best valid pair. `done` pulses for one cycle when the result is ready. The result outputs keep their values until the next accepted request. Requests above 400 kHz select high-speed mode, which narrows the step-count range.

Top module: `i2c_div_solver`

## Requirements
- R1: A request whose bus rate is 0 or greater than 3,400,000 is rejected. `done` pulses with `err`=1, and `sample_cnt`, `step_cnt`, `sample_code` and `step_code` are all zero.
- R2: `hs_mode` is 1 exactly when the requested rate is greater than 400,000. In that mode the step count is at most 8; otherwise it is at most 64.
- R3: The target divisor is T = ceil(floor(src_hz/2) / bus_hz), raised to 1 when it computes to 0.
- R4: On success, `sample_cnt` is in 1..8 and `step_cnt` = ceil(T/`sample_cnt`), which is within the mode limit. The product of the two is the smallest such product. On equal products the lowest sample count wins.
- R5: When no sample count in 1..8 gives a step count within the mode limit (T greater than 8 times the limit), `done` pulses with `err`=1 and all counts and codes are zero.
- R6: `sample_code` = `sample_cnt`−1 in 3 bits and `step_code` = `step_cnt`−1 in 6 bits. In high-speed mode only the low 3 bits of `step_code` can be non-zero.
- R7: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after acceptance until `done`. A `start` while `busy` is high is ignored and does not change the result.
- R8: After reset `done`, `err`, `busy`, `hs_mode` and every count and code output are 0.
- R9: Result outputs keep their values from one `done` until the next accepted request finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when idle |
| src_hz | input | 32 | Source clock frequency in Hz |
| bus_hz | input | 32 | Requested bus rate in Hz |
| busy | output | 1 | Solver working |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request could not be met |
| hs_mode | output | 1 | High-speed mode selected |
| sample_cnt | output | 4 | Chosen sample count |
| step_cnt | output | 7 | Chosen step count |
| sample_code | output | 3 | Sample count minus one |
| step_code | output | 6 | Step count minus one |

## Verification
A bad restoring-divider step shows up as a wrong target divisor. That in turn gives a wrong pair, or a false error, at the very next `done`, about forty cycles after `start`. A wrong running-best register in the search makes the pair wrong, or breaks the tie toward the wrong sample count. The vector table therefore includes targets where several sample counts reach the same product. Faults in the sequencing show up in the same request. They appear as a missing or stretched `done`, a `start` that was taken while busy, or result outputs that drift between requests.

// File: rtl/i2c_div_pkg.sv
package i2c_div_pkg;

  typedef enum logic [1:0] {
    SOLVE_IDLE,
    SOLVE_DIV,
    SOLVE_SRCH
  } solve_state_t;

endpackage

// File: rtl/i2c_div_udiv.sv
// Restoring unsigned divider: one quotient bit per cycle, W cycles per result.
module i2c_div_udiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  den_q;
  logic [W-1:0]  num_q;
  logic [W:0]    shifted;
  logic [W:0]    diff;
  logic          fits;

  always_comb begin
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, den_q};
    fits    = ~diff[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      quo   <= '0;
      rem   <= '0;
      den_q <= '0;
      num_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt   <= CW'(W);
        quo   <= num;
        rem   <= '0;
        den_q <= den;
        num_q <= num;
      end else if (busy) begin
        rem <= fits ? diff[W-1:0] : shifted[W-1:0];
        quo <= {quo[W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // The quotient and remainder reproduce the latched numerator (R3).
  assert_div_identity_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (({{W{1'b0}}, quo} * {{W{1'b0}}, den_q}) + {{W{1'b0}}, rem}
              == {{W{1'b0}}, num_q}));

  assert_div_rem_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem < den_q));

endmodule

// File: rtl/i2c_div_search.sv
// Tries sample counts 1..SAMPLE_MAX, one per cycle, keeping the smallest product.
module i2c_div_search #(
  parameter int SAMPLE_MAX = 8,
  parameter int TW         = 10,
  parameter int SW         = 4,
  parameter int PW         = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [TW-1:0] tgt,
  input  logic [PW-1:0] step_lim,
  output logic          fin,
  output logic          found,
  output logic [SW-1:0] best_s,
  output logic [PW-1:0] best_step
);
  localparam int PRW = SW + PW;

  logic           active;
  logic [SW-1:0]  cur_s;
  logic [PRW-1:0] best_prod;

  logic [TW:0]    numr;
  logic [TW:0]    divisor;
  logic [TW:0]    cand;
  logic           valid;
  logic [PRW-1:0] prod;

  always_comb begin
    divisor = (cur_s == '0) ? (TW+1)'(1) : (TW+1)'(cur_s);
    numr    = {1'b0, tgt} + divisor - (TW+1)'(1);
    cand    = numr / divisor;
    valid   = (cand <= (TW+1)'(step_lim)) && (cand != '0);
    prod    = PRW'(cand[PW-1:0]) * PRW'(cur_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cur_s     <= '0;
      fin       <= 1'b0;
      found     <= 1'b0;
      best_s    <= '0;
      best_step <= '0;
      best_prod <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active    <= 1'b1;
        cur_s     <= SW'(1);
        found     <= 1'b0;
        best_s    <= '0;
        best_step <= '0;
        best_prod <= PRW'(SAMPLE_MAX) * PRW'(step_lim);
      end else if (active) begin
        if (valid && (!found || prod < best_prod)) begin
          found     <= 1'b1;
          best_s    <= cur_s;
          best_step <= cand[PW-1:0];
          best_prod <= prod;
        end
        if (cur_s == SW'(SAMPLE_MAX)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end else begin
          cur_s <= cur_s + 1'b1;
        end
      end
    end
  end

  // The candidate sample count stays inside its legal range (R4).
  assert_sample_range_R4: assert property (@(posedge clk) disable iff (rst)
    active |-> (cur_s >= SW'(1) && cur_s <= SW'(SAMPLE_MAX)));

  // A kept pair never breaks the mode step limit (R2).
  assert_best_within_limit_R2: assert property (@(posedge clk) disable iff (rst)
    (fin && found) |-> (best_step <= step_lim && best_step != '0));

endmodule

// File: rtl/i2c_div_solver.sv
module i2c_div_solver #(
  parameter int FW          = 32,
  parameter int SAMPLE_MAX  = 8,
  parameter int STEP_MAX_FS = 64,
  parameter int STEP_MAX_HS = 8,
  parameter int FS_LIMIT_HZ = 400000,
  parameter int HS_LIMIT_HZ = 3400000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [FW-1:0]                  src_hz,
  input  logic [FW-1:0]                  bus_hz,
  output logic                           busy,
  output logic                           done,
  output logic                           err,
  output logic                           hs_mode,
  output logic [$clog2(SAMPLE_MAX+1)-1:0]  sample_cnt,
  output logic [$clog2(STEP_MAX_FS+1)-1:0] step_cnt,
  output logic [$clog2(SAMPLE_MAX)-1:0]    sample_code,
  output logic [$clog2(STEP_MAX_FS)-1:0]   step_code
);
  import i2c_div_pkg::*;

  localparam int SW   = $clog2(SAMPLE_MAX + 1);
  localparam int PW   = $clog2(STEP_MAX_FS + 1);
  localparam int SCW  = $clog2(SAMPLE_MAX);
  localparam int STCW = $clog2(STEP_MAX_FS);
  localparam int TW   = $clog2(SAMPLE_MAX * STEP_MAX_FS + 1);

  solve_state_t  state;
  logic          hs_q;
  logic [PW-1:0] lim_q;
  logic [FW-1:0] num_q;
  logic [FW-1:0] den_q;
  logic [TW-1:0] tgt_q;
  logic          div_start;
  logic          srch_go;

  logic          div_busy;
  logic          div_done;
  logic [FW-1:0] div_quo;
  logic [FW-1:0] div_rem;

  logic          srch_fin;
  logic          srch_found;
  logic [SW-1:0] srch_s;
  logic [PW-1:0] srch_step;

  logic          req_bad;
  logic          req_hs;
  logic [FW-1:0] tgt_full;
  logic          tgt_big;

  always_comb begin
    req_bad  = (bus_hz == '0) || (bus_hz > FW'(HS_LIMIT_HZ));
    req_hs   = (bus_hz > FW'(FS_LIMIT_HZ));
    tgt_full = (div_quo == '0) ? FW'(1) : div_quo;
    tgt_big  = tgt_full > (FW'(SAMPLE_MAX) * FW'(lim_q));
  end

  i2c_div_udiv #(.W(FW)) u_udiv (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .num   (num_q),
    .den   (den_q),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo),
    .rem   (div_rem)
  );

  i2c_div_search #(
    .SAMPLE_MAX (SAMPLE_MAX),
    .TW         (TW),
    .SW         (SW),
    .PW         (PW)
  ) u_search (
    .clk       (clk),
    .rst       (rst),
    .go        (srch_go),
    .tgt       (tgt_q),
    .step_lim  (lim_q),
    .fin       (srch_fin),
    .found     (srch_found),
    .best_s    (srch_s),
    .best_step (srch_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SOLVE_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      hs_mode     <= 1'b0;
      sample_cnt  <= '0;
      step_cnt    <= '0;
      sample_code <= '0;
      step_code   <= '0;
      hs_q        <= 1'b0;
      lim_q       <= '0;
      num_q       <= '0;
      den_q       <= '0;
      tgt_q       <= '0;
      div_start   <= 1'b0;
      srch_go     <= 1'b0;
    end else begin
      done      <= 1'b0;
      div_start <= 1'b0;
      srch_go   <= 1'b0;
      unique case (state)
        SOLVE_IDLE: begin
          if (start) begin
            if (req_bad) begin
              done        <= 1'b1;
              err         <= 1'b1;
              hs_mode     <= req_hs;
              sample_cnt  <= '0;
              step_cnt    <= '0;
              sample_code <= '0;
              step_code   <= '0;
            end else begin
              hs_q      <= req_hs;
              lim_q     <= req_hs ? PW'(STEP_MAX_HS) : PW'(STEP_MAX_FS);
              num_q     <= (src_hz >> 1) + bus_hz - FW'(1);
              den_q     <= bus_hz;
              div_start <= 1'b1;
              busy      <= 1'b1;
              state     <= SOLVE_DIV;
            end
          end
        end
        SOLVE_DIV: begin
          if (div_done) begin
            if (tgt_big) begin
              done        <= 1'b1;
              err         <= 1'b1;
              hs_mode     <= hs_q;
              sample_cnt  <= '0;
              step_cnt    <= '0;
              sample_code <= '0;
              step_code   <= '0;
              busy        <= 1'b0;
              state       <= SOLVE_IDLE;
            end else begin
              tgt_q   <= TW'(tgt_full);
              srch_go <= 1'b1;
              state   <= SOLVE_SRCH;
            end
          end
        end
        SOLVE_SRCH: begin
          if (srch_fin) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            hs_mode <= hs_q;
            state   <= SOLVE_IDLE;
            if (srch_found) begin
              err         <= 1'b0;
              sample_cnt  <= srch_s;
              step_cnt    <= srch_step;
              sample_code <= SCW'(srch_s - SW'(1));
              step_code   <= STCW'(srch_step - PW'(1));
            end else begin
              err         <= 1'b1;
              sample_cnt  <= '0;
              step_cnt    <= '0;
              sample_code <= '0;
              step_code   <= '0;
            end
          end
        end
        default: state <= SOLVE_IDLE;
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  assert_step_limit_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (step_cnt <= (hs_mode ? PW'(STEP_MAX_HS) : PW'(STEP_MAX_FS))));

  assert_product_covers_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ((SW+PW)'(sample_cnt) * (SW+PW)'(step_cnt) >= (SW+PW)'(tgt_q)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(sample_cnt) && $stable(step_cnt) && $stable(err)));

  assert_div_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (state == SOLVE_IDLE) |-> !div_busy);

endmodule

// File: tb/i2c_div_solver_bench.sv
module i2c_div_solver_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] src_hz;
  logic [31:0] bus_hz;
  logic        busy, done, err, hs_mode;
  logic [3:0]  sample_cnt;
  logic [6:0]  step_cnt;
  logic [2:0]  sample_code;
  logic [5:0]  step_code;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  i2c_div_solver u_i2c_div_solver (
    .clk(clk), .rst(rst), .start(start), .src_hz(src_hz), .bus_hz(bus_hz),
    .busy(busy), .done(done), .err(err), .hs_mode(hs_mode),
    .sample_cnt(sample_cnt), .step_cnt(step_cnt),
    .sample_code(sample_code), .step_code(step_code)
  );

  localparam int NV = 14;
  localparam logic [63:0] VEC [NV] = '{
    {32'd100000000, 32'd100000},
    {32'd100000000, 32'd400000},
    {32'd100000000, 32'd400001},
    {32'd100000000, 32'd1000000},
    {32'd100000000, 32'd3400000},
    {32'd102400000, 32'd100000},
    {32'd200000000, 32'd100000},
    {32'd100000000, 32'd500000},
    {32'd1,         32'd100000},
    {32'd26000000,  32'd100000},
    {32'd66000000,  32'd400000},
    {32'd13000000,  32'd3400000},
    {32'd100000000, 32'd3400001},
    {32'd100000000, 32'd0}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference built from the requirement text.
  task automatic model(input longint src, input longint bus,
                       output bit e, output bit h, output int s, output int st);
    longint t;
    int mx, bp;
    bit f;
    h = (bus > 400000);
    s = 0; st = 0; e = 0; f = 0; bp = 0;
    if (bus == 0 || bus > 3400000) begin
      e = 1;
      return;
    end
    mx = h ? 8 : 64;
    t = ((src / 2) + bus - 1) / bus;
    if (t == 0) t = 1;
    for (int k = 1; k <= 8; k++) begin
      longint c;
      c = (t + k - 1) / k;
      if (c <= mx && (!f || c * k < bp)) begin
        f = 1; s = k; st = int'(c); bp = int'(c) * k;
      end
    end
    if (!f) begin e = 1; s = 0; st = 0; end
  endtask

  task automatic run_op(input logic [31:0] sv, input logic [31:0] bv, output bit ok);
    int n;
    @(negedge clk);
    src_hz = sv; bus_hz = bv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    ok = 1'b0;
    while (n < 200) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
      n++;
    end
    if (!ok) check(1'b0, "R7 watchdog", n, 0);
  endtask

  task automatic check_result(input logic [31:0] sv, input logic [31:0] bv);
    bit e, h;
    int s, st;
    model(sv, bv, e, h, s, st);
    check(err == e, (e && (bv == 0 || bv > 3400000)) ? "R1 err" : "R5 err", err, e);
    check(hs_mode == h, "R2 mode", hs_mode, h);
    check(sample_cnt == s, "R4 sample", sample_cnt, s);
    check(step_cnt == st, "R3 R4 step", step_cnt, st);
    check(sample_code == (e ? 0 : 3'(s - 1)), "R6 sample code", sample_code, e ? 0 : s - 1);
    check(step_code == (e ? 0 : 6'(st - 1)), "R6 step code", step_code, e ? 0 : st - 1);
  endtask

  initial begin
    bit ok;
    rst = 1'b1; start = 1'b0; src_hz = '0; bus_hz = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(!done && !err && !busy && !hs_mode, "R8 flags", {done, err, busy, hs_mode}, 0);
    check(sample_cnt == 0 && step_cnt == 0 && sample_code == 0 && step_code == 0,
          "R8 counts", sample_cnt, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][63:32], VEC[i][31:0], ok);
      if (ok) check_result(VEC[i][63:32], VEC[i][31:0]);
    end

    // R7: done lasts one cycle; R9: results hold afterwards
    run_op(32'd100000000, 32'd400000, ok);
    @(negedge clk);
    check(!done, "R7 done width", done, 0);
    repeat (5) @(negedge clk);
    check(sample_cnt == 5 && step_cnt == 25 && !err, "R9 hold", sample_cnt, 5);

    // R7: start while busy is ignored
    @(negedge clk);
    src_hz = 32'd100000000; bus_hz = 32'd1000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy, "R7 busy", busy, 1);
    src_hz = 32'd100000000; bus_hz = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      if (n >= 200) check(1'b0, "R7 watchdog", n, 0);
    end
    check(!err && sample_cnt == 7 && step_cnt == 8, "R7 start ignored", sample_cnt, 7);
    check(step_code[5:3] == 0, "R6 hs code width", step_code, 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R7 global watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule